// File: doc/BRIEF.md
# Serial Peripheral Transfer Sequencer

This block runs one byte-wide serial transfer at a time, in either controller (master) or target (slave) mode. It decides when a transfer begins and counts serial clock edges until the byte is finished. It then waits through two settling states and ends with a single completion state. In that state it copies the shift register into a read buffer and raises a one-cycle flag request toward a separate status register. Data leaves and enters most-significant bit first. The clock phase setting decides on which edge a bit is sampled and on which edge the next bit is presented. The clock polarity setting gives the idle level of the serial clock.

Software writes the outgoing byte through a valid/ready write port at the data offset. The write lands straight in the shift register and, in controller mode, starts the transfer. Reads at the same offset return the read buffer, so a new transfer can start before the previous result has been read. The bit-rate prescaler supplies a one-cycle tick input. Pin direction control lies outside the block, so the clock, controller-in and controller-out lines come as separate input and output ports.

Write-port rules: `wr_ready` is high only while the block is enabled and idle. A write is taken in any cycle where `wr_valid` and `wr_ready` are both high. `wr_valid` may stay high while `wr_ready` is low, and the write then waits. The read port is combinational and has no handshake.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: In controller mode (`master`=1), an accepted write whose `wr_addr` is 0x2A loads `wr_data` and starts a transfer. `sck_out` then toggles once per `rate_tick`, for 16 toggles in total.
- R2: In target mode with `cpha`=0, a transfer starts only on a high-to-low change of `ss_n`. Edges on `sck_in` while idle do not start one.
- R3: In target mode with `cpha`=1, a transfer starts on the first edge seen on `sck_in`. A falling `ss_n` alone does not start one.
- R4: A transfer ends after 16 serial clock edges. Two settling cycles follow, then one completion cycle, then idle. In controller mode, `set_flag` is high exactly 2 cycles after the final `sck_out` toggle.
- R5: `set_flag` is a one-cycle pulse, given exactly once for each completed transfer.
- R6: After completion, reading `rd_addr`=0x2A returns the 8 bits received, with the first received bit in bit 7. Any other read address returns 0.
- R7: The read buffer keeps the previous result while a new byte is loaded and shifted. It changes only at completion.
- R8: In controller mode, serial input comes from `mi`, the output goes to `mo`, and `so` is 0. In target mode, input comes from `si`, output goes to `so`, and `mo` is 0. While no transfer runs, `sck_out` sits at the `cpol` level.
- R9: `wr_ready` is 1 only when `en`=1 and the block is idle. An accepted write to any address other than 0x2A changes nothing and starts nothing.
- R10: `en`=0 forces the block idle at the next clock edge. It aborts any transfer without raising `set_flag` and discards the pending data.
- R11: With `cpha`=0, the input is sampled on the leading edge (the edge away from the `cpol` level) and the next bit is presented on the trailing edge. With `cpha`=1, the next bit is presented on each leading edge after the first, and the input is sampled on the trailing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low forces idle |
| master | input | 1 | 1 = controller mode, 0 = target mode |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Serial clock phase select |
| rate_tick | input | 1 | One-cycle tick from the bit-rate prescaler |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request can be taken |
| wr_addr | input | 8 | Register-block write offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Register-block read offset |
| rd_data | output | 8 | Read data (read buffer at 0x2A, else 0) |
| sck_in | input | 1 | Serial clock from the external controller |
| sck_out | output | 1 | Serial clock produced in controller mode |
| ss_n | input | 1 | Active-low target select |
| mi | input | 1 | Controller-in serial line |
| si | input | 1 | Target-in serial line |
| mo | output | 1 | Controller-out serial line |
| so | output | 1 | Target-out serial line |
| set_flag | output | 1 | Completion flag request, one-cycle pulse |

## Verification
The assertions assume that `cpol`, `cpha` and `master` change only while `en` is low. They also assume that `sck_in` rests at the `cpol` level before `en` rises, so the synchronizer never reports a false edge. Each `sck_in` half-period lasts several system cycles, so that the two-stage synchronizer and the edge detector can follow the clock. The bench keeps within these limits: it drops `en` before every change of mode, parks `sck_in` at its idle level, and drives target-mode half-periods of six cycles. Bytes and mode bits are drawn from a fixed-seed random stream, and directed cases cover aborts, ignored addresses and start conditions that must not trigger.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_DLY1,
    ST_DLY2,
    ST_DONE
  } xfer_state_e;
endpackage

// File: rtl/spi_edge_gen.sv
// Serial clock source selection and edge classification.
module spi_edge_gen #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic master,
  input  logic cpol,
  input  logic run,
  input  logic rate_tick,
  input  logic sck_in,
  input  logic ss_n,
  output logic edge_ev,
  output logic edge_lead,
  output logic sck_out,
  output logic ss_fall
);
  logic [SYNC-1:0] sck_sync, ss_sync;
  logic sck_prev, ss_prev, sck_lvl;
  logic s_ev, m_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync <= '0;
      ss_sync  <= '1;
      sck_prev <= 1'b0;
      ss_prev  <= 1'b1;
    end else begin
      sck_sync <= {sck_sync[SYNC-2:0], sck_in};
      ss_sync  <= {ss_sync[SYNC-2:0], ss_n};
      sck_prev <= sck_sync[SYNC-1];
      ss_prev  <= ss_sync[SYNC-1];
    end
  end

  // Generated clock: parks at idle level whenever no transfer runs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sck_lvl <= 1'b0;
    else if (!en || !run)    sck_lvl <= cpol;
    else if (rate_tick)      sck_lvl <= ~sck_lvl;
  end

  assign s_ev = sck_sync[SYNC-1] ^ sck_prev;
  assign m_ev = run && rate_tick;

  always_comb begin
    if (master) begin
      edge_ev   = m_ev;
      edge_lead = m_ev && (sck_lvl == cpol);
    end else begin
      edge_ev   = s_ev && en;
      edge_lead = s_ev && en && (sck_prev == cpol);
    end
  end

  assign sck_out = sck_lvl;
  assign ss_fall = en && ss_prev && !ss_sync[SYNC-1];

  // R11: generated edges alternate leading/trailing
  p_lead_alt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (master && run && m_ev && $past(run) && $stable(cpol)) |=> (sck_out != $past(sck_out)));
endmodule

// File: rtl/spi_shifter.sv
// Shift register, sampled-bit holder and read buffer.
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         samp_en,
  input  logic         shift_en,
  input  logic         latch,
  input  logic         sin,
  output logic         sout,
  output logic [W-1:0] rbuf
);
  logic [W-1:0] sr;
  logic         smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      smp  <= 1'b0;
      rbuf <= '0;
    end else begin
      if (load)          sr <= load_data;
      else if (shift_en) sr <= {sr[W-2:0], smp};
      if (samp_en)       smp <= sin;
      if (latch)         rbuf <= sr;
    end
  end

  assign sout = sr[W-1];

  // R6: the buffer copy never coincides with a shift or a load
  p_latch_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> !(shift_en || load));
endmodule

// File: rtl/spi_seq_fsm.sv
// Transfer sequencer: start detection, edge counting, settle and completion.
module spi_seq_fsm
  import spi_xfer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        master,
  input  logic        cpha,
  input  logic        load,
  input  logic        edge_ev,
  input  logic        edge_lead,
  input  logic        ss_fall,
  output xfer_state_e st,
  output logic        run,
  output logic        samp_en,
  output logic        shift_en,
  output logic        latch,
  output logic        set_flag
);
  localparam int NEDGE = 2 * W;
  localparam int CNTW  = $clog2(NEDGE + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(NEDGE - 1);

  logic [CNTW-1:0] cnt;
  logic data_full;
  logic start_m, start_s0, start_s1, act_edge, first;

  assign start_m  = master && data_full;
  assign start_s0 = !master && !cpha && ss_fall;
  assign start_s1 = !master && cpha && edge_ev;

  assign act_edge = edge_ev && ((st == ST_XFER) || (st == ST_IDLE && start_s1));
  assign first    = (st == ST_IDLE) || (cnt == '0);

  assign samp_en  = act_edge && (cpha ? !edge_lead : edge_lead);
  assign shift_en = (act_edge && (cpha ? (edge_lead && !first) : !edge_lead))
                  || (st == ST_DLY1 && cpha);
  assign latch    = (st == ST_DONE);
  assign set_flag = (st == ST_DONE);
  assign run      = (st == ST_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      data_full <= 1'b0;
    end else if (!en) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      data_full <= 1'b0;
    end else begin
      if (load) data_full <= 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (start_m || start_s0) begin
            st  <= ST_XFER;
            cnt <= '0;
          end else if (start_s1) begin
            st  <= ST_XFER;
            cnt <= CNTW'(1);
          end
        end
        ST_XFER: begin
          if (edge_ev) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) st <= ST_DLY1;
          end
        end
        ST_DLY1: st <= ST_DLY2;
        ST_DLY2: st <= ST_DONE;
        ST_DONE: begin
          st        <= ST_IDLE;
          data_full <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: completion lasts one cycle and returns to idle
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |=> (st == ST_IDLE));
  // R4: settling states run in order unless disabled
  p_dly_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DLY1) |=> (st == ST_DLY2 || !$past(en)));
  // R4: edge count stays within one byte
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER) |-> (cnt < CNTW'(NEDGE)));
  // R10: disable forces idle on the next edge
  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == ST_IDLE));
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int          W        = 8,
  parameter int          AW       = 8,
  parameter logic [7:0]  DATA_OFS = 8'h2A,
  parameter int          SYNC     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          master,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          rate_tick,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          sck_in,
  output logic          sck_out,
  input  logic          ss_n,
  input  logic          mi,
  input  logic          si,
  output logic          mo,
  output logic          so,
  output logic          set_flag
);
  localparam logic [AW-1:0] OFS = AW'(DATA_OFS);

  xfer_state_e st;
  logic run, edge_ev, edge_lead, ss_fall;
  logic samp_en, shift_en, latch, load, sin, sout;
  logic [W-1:0] rbuf;

  assign wr_ready = en && (st == ST_IDLE);
  assign load     = wr_valid && wr_ready && (wr_addr == OFS);
  assign sin      = master ? mi : si;
  assign mo       = master ? sout : 1'b0;
  assign so       = master ? 1'b0 : sout;
  assign rd_data  = (rd_addr == OFS) ? rbuf : '0;

  spi_edge_gen #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpol(cpol),
    .run(run), .rate_tick(rate_tick), .sck_in(sck_in), .ss_n(ss_n),
    .edge_ev(edge_ev), .edge_lead(edge_lead), .sck_out(sck_out),
    .ss_fall(ss_fall)
  );

  spi_seq_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpha(cpha),
    .load(load), .edge_ev(edge_ev), .edge_lead(edge_lead), .ss_fall(ss_fall),
    .st(st), .run(run), .samp_en(samp_en), .shift_en(shift_en),
    .latch(latch), .set_flag(set_flag)
  );

  spi_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(wr_data),
    .samp_en(samp_en), .shift_en(shift_en), .latch(latch), .sin(sin),
    .sout(sout), .rbuf(rbuf)
  );

  // R5: flag request is a single-cycle pulse
  p_flag_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_flag |=> !set_flag);
  // R7: visible read data changes only right after completion
  p_buf_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr) && !$stable(rd_data)) |-> ($past(st) == ST_DONE));
  // R8: generated clock rests at the idle level outside a transfer
  p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $stable(cpol) && $past(st) != ST_XFER && st != ST_XFER)
      |-> (sck_out == cpol));
endmodule

// File: tb/spi_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module spi_xfer_ctrl_tb;
  localparam int H = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, master = 1, cpol = 0, cpha = 0, rate_tick = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] wr_addr = 8'h2A, wr_data = 0, rd_addr = 8'h2A, rd_data;
  logic sck_in = 0, sck_out, ss_n = 1, mi = 0, si = 0, mo, so, set_flag;

  int n_chk = 0, n_fail = 0, cyc = 0, flag_cnt = 0, tcnt = 0;
  int last_edge_cyc = 0, flag_cyc = 0;
  logic flag_prev = 0, finished = 0;
  logic peer_on = 0, p_prev = 0;
  logic [7:0] pbyte = 0, cap = 0, prev_rx = 0;
  int pidx = 0;

  always #2.5 clk = ~clk;

  spi_xfer_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpol(cpol),
    .cpha(cpha), .rate_tick(rate_tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sck_in(sck_in),
    .sck_out(sck_out), .ss_n(ss_n), .mi(mi), .si(si), .mo(mo), .so(so),
    .set_flag(set_flag)
  );

  function automatic logic bit_at(input logic [7:0] b, input int i);
    return b[7 - i]; // MSB first
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (set_flag) flag_cnt <= flag_cnt + 1;
  end

  always @(negedge clk) begin
    tcnt = tcnt + 1;
    rate_tick = (tcnt % 4 == 0);
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  // completion timestamp (R4)
  always @(negedge clk) begin
    if (set_flag && !flag_prev) flag_cyc = cyc;
    flag_prev = set_flag;
  end

  // behavioural target peer for controller-mode transfers (R11)
  always @(negedge clk) begin
    if (peer_on && sck_out != p_prev) begin
      if (!cpha) begin
        if (p_prev == cpol) cap = {cap[6:0], mo};
        else begin
          pidx++;
          if (pidx < 8) mi = bit_at(pbyte, pidx);
        end
      end else begin
        if (p_prev == cpol) begin
          mi = bit_at(pbyte, pidx);
          pidx++;
        end else cap = {cap[6:0], mo};
      end
      last_edge_cyc = cyc;
    end
    p_prev = sck_out;
  end

  task automatic setup(input logic m, input logic cp, input logic ch);
    @(negedge clk); en = 0;
    repeat (2) @(negedge clk);
    master = m; cpol = cp; cpha = ch; sck_in = cp; ss_n = 1;
    repeat (6) @(negedge clk);
    en = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    chk(wr_ready == 1'b1, "R9 ready before write", wr_ready, 1);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0; wr_addr = 8'h2A;
  endtask

  task automatic do_master(input logic cp, input logic ch, input logic [7:0] tx,
                           input logic [7:0] pb);
    int f0;
    setup(1, cp, ch);
    pbyte = pb; pidx = 0; cap = 0; p_prev = cp;
    mi = ch ? 1'b0 : bit_at(pb, 0);
    peer_on = 1;
    f0 = flag_cnt;
    write(8'h2A, tx);
    repeat (10) @(negedge clk);
    chk(wr_ready == 1'b0, "R9 ready low in transfer", wr_ready, 0);
    chk(rd_data == prev_rx, "R7 buffer held during transfer", rd_data, prev_rx);
    chk(so == 1'b0, "R8 so idle in controller mode", so, 0);
    for (int i = 0; i < 2000 && flag_cnt == f0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    peer_on = 0;
    chk(flag_cnt == f0 + 1, "R5 one flag per transfer", flag_cnt - f0, 1);
    chk(cap == tx, "R11 R8 bits on mo", cap, tx);
    chk(rd_data == pb, "R1 R6 received byte", rd_data, pb);
    chk(flag_cyc - last_edge_cyc == 2, "R4 flag after last edge", flag_cyc - last_edge_cyc, 2);
    chk(sck_out == cp, "R8 sck idle level", sck_out, cp);
    prev_rx = pb;
  endtask

  task automatic do_slave(input logic cp, input logic ch, input logic [7:0] tx,
                          input logic [7:0] pb);
    int f0;
    setup(0, cp, ch);
    f0 = flag_cnt;
    write(8'h2A, tx);
    if (!ch) begin
      sck_in = ~cp; repeat (H) @(negedge clk);
      sck_in = cp;  repeat (H) @(negedge clk);
      chk(wr_ready == 1'b1, "R2 sck edge does not start", wr_ready, 1);
    end else begin
      ss_n = 0; repeat (H) @(negedge clk);
      chk(wr_ready == 1'b1, "R3 ss fall does not start", wr_ready, 1);
    end
    ss_n = 0;
    cap = 0;
    if (!ch) si = bit_at(pb, 0);
    repeat (H) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!ch) begin
        sck_in = ~cp; repeat (H) @(negedge clk);
        cap = {cap[6:0], so};
        sck_in = cp;
        if (i < 7) si = bit_at(pb, i + 1);
        repeat (H) @(negedge clk);
      end else begin
        sck_in = ~cp; si = bit_at(pb, i); repeat (H) @(negedge clk);
        cap = {cap[6:0], so};
        sck_in = cp; repeat (H) @(negedge clk);
      end
      if (i == 0) chk(mo == 1'b0, "R8 mo idle in target mode", mo, 0);
    end
    repeat (20) @(negedge clk);
    ss_n = 1;
    chk(flag_cnt == f0 + 1, ch ? "R3 R5 target flag" : "R2 R5 target flag", flag_cnt - f0, 1);
    chk(cap == tx, "R11 R8 bits on so", cap, tx);
    chk(rd_data == pb, "R6 target received byte", rd_data, pb);
    prev_rx = pb;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(wr_ready == 1'b0, "R10 reset ready low", wr_ready, 0);
    chk(set_flag == 1'b0, "R5 reset flag low", set_flag, 0);
    chk(rd_data == 8'h00, "R6 reset buffer", rd_data, 0);

    do_master(0, 0, 8'hA5, 8'h3C);
    do_master(1, 1, 8'h01, 8'h80);
    do_slave(0, 0, 8'hC3, 8'h5A);
    do_slave(1, 1, 8'h7E, 8'hFF);

    // R6: other read address returns zero
    rd_addr = 8'h2B; @(negedge clk);
    chk(rd_data == 8'h00, "R6 other read address", rd_data, 0);
    rd_addr = 8'h2A; @(negedge clk);

    // R9: write to other address ignored
    begin
      int f0;
      setup(1, 0, 0);
      f0 = flag_cnt;
      write(8'h2B, 8'h55);
      repeat (60) @(negedge clk);
      chk(flag_cnt == f0, "R9 other address no transfer", flag_cnt - f0, 0);
      chk(wr_ready == 1'b1 && sck_out == 1'b0, "R9 still idle", {wr_ready, sck_out}, 2);
    end

    // R10: abort by disable
    begin
      int f0;
      setup(1, 1, 0);
      f0 = flag_cnt;
      write(8'h2A, 8'h99);
      repeat (20) @(negedge clk);
      en = 0;
      @(negedge clk);
      chk(wr_ready == 1'b0, "R10 ready low when disabled", wr_ready, 0);
      @(negedge clk);
      chk(sck_out == 1'b1, "R10 sck back to idle", sck_out, 1);
      en = 1;
      repeat (200) @(negedge clk);
      chk(flag_cnt == f0, "R10 no flag after abort", flag_cnt - f0, 0);
      chk(rd_data == prev_rx, "R10 R7 buffer kept", rd_data, prev_rx);
    end

    for (int k = 0; k < 12; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[0]) do_master(r[1], r[2], r[15:8], r[23:16]);
      else      do_slave(r[1], r[2], r[15:8], r[23:16]);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule